// File: doc/BRIEF.md
# Incoming/Victim Pair History Tracker

This block keeps a small set-associative record of recent cache misses, for a bypass predictor that learns from what an ideal bypass decision would have done. Each record pairs the partial tag of the block that missed (the insert tag) with the partial tag of the block the cache's replacement policy offered as victim (the evict tag). It also keeps a signature: the requesting program-counter bits for demand misses, or the core number for prefetch misses, with a flag marking which one it holds. Every later access is compared against the valid records of its set. When one member of a pair is touched first, the block emits a training event that says whether inserting or bypassing would have been correct. It then frees that record.

Accesses arrive one at a time with a valid strobe and are accepted while `acc_ready` is high. All records that match one access are retired in the accept cycle. Their events then leave on the event port one per cycle, lowest way first, starting the cycle after acceptance, and `acc_ready` stays low until the last one has gone. A miss is recorded into the lowest free way of its set. If the set is full, a 9-bit LFSR decides about once in 511 full-set misses to overwrite the least recently recorded way. The address carries the partial tag in its low 21 bits and the 3-bit set index directly above it.

Top module: `pairhist_tracker`

## Requirements
- R1: After reset no event is pending (`evt_valid` low) and `acc_ready` is high.
- R2: A demand access whose tag equals the insert tag of a valid record emits event code 1 with that record's signature and prefetch flag, and retires the record, so a repeat of the access emits nothing.
- R3: A demand access whose tag equals the evict tag of a valid record emits event code 2 with the stored signature and retires the record.
- R4: A miss, demand or prefetch, whose victim-candidate tag equals the insert tag of a valid record emits event code 3 with the stored signature and retires the record.
- R5: A prefetch access never produces code 1 or 2. A recorded prefetch miss stores the core number, zero-extended, as its signature and sets the prefetch flag (reported as `evt_pf` = 1). The program-counter input is then ignored.
- R6: When several records of a set match one access, each gives exactly one event, one per cycle, in ascending way order. `acc_ready` is low while any of them is still pending.
- R7: Within one record the checks have a fixed priority: an insert-tag match on a demand access (code 1) wins over an evict-tag match (code 2), which wins over a victim-candidate match (code 3).
- R8: Every miss is recorded when its set has a free way after the access's own retirements. Records are matched only by accesses to the same set index (address bits 23:21).
- R9: A miss that finds its set full is recorded only when the LFSR (x^9+x^5+1, seeded to 1, advanced once per full-set miss) is at its seed value. After reset the first full-set miss is recorded, the next 510 are not, and the 511th after the first is.
- R10: A recording into a full set overwrites the record written least recently in that set.
- R11: The first event of an access is visible in the cycle right after the access is accepted, and no event appears without an accepted access before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Access present |
| acc_ready | output | 1 | Block can accept an access (no events pending) |
| acc_demand | input | 1 | 1 = demand access, 0 = prefetch access |
| acc_miss | input | 1 | The access missed in the cache |
| acc_addr | input | 24 | Bits 20:0 partial tag, bits 23:21 set index |
| acc_victim_tag | input | 21 | Partial tag of the replacement policy's victim candidate (used on a miss) |
| acc_pc_sig | input | 10 | Program-counter signature of a demand access |
| acc_core | input | 2 | Requesting core number |
| evt_valid | output | 1 | Training event present this cycle |
| evt_code | output | 2 | 1 insert was right, 2 bypass was right, 3 neither reused |
| evt_sig | output | 10 | Signature stored with the retired record |
| evt_pf | output | 1 | Retired record came from a prefetch miss |

## Verification
A record written to the wrong way, with a bad valid bit or with a stale signature shows up at the first access that should touch it: an event is missing, extra, or carries the wrong code, signature or order, one cycle after that access. A corrupt replacement order stays hidden until a set fills and the LFSR lets a full-set miss through; the wrong pair is then lost. That can take hundreds of misses, so the bench drives a set through a full LFSR period and then probes which pairs survived. A wrong LFSR sequence likewise only shows as a record taken or skipped at the wrong full-set miss.

// File: rtl/pairhist_pkg.sv
package pairhist_pkg;

   typedef enum logic [1:0] {
      EV_NONE       = 2'd0,
      EV_INSERT_WON = 2'd1,
      EV_VICTIM_WON = 2'd2,
      EV_NEITHER    = 2'd3
   } ph_event_e;

   localparam int unsigned PH_CODE_W = 2;

endpackage

// File: rtl/pairhist_lfsr.sv
module pairhist_lfsr #(
   parameter int unsigned W    = 9,
   parameter logic [W-1:0] TAPS = 9'h110,
   parameter logic [W-1:0] SEED = 9'h001
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         step,
   output logic [W-1:0] state,
   output logic         at_seed
);

   generate
      if (W < 3) begin : g_bad_w
         $error("pairhist_lfsr: width too small");
      end
      if (SEED == '0) begin : g_bad_seed
         $error("pairhist_lfsr: seed must be nonzero");
      end
   endgenerate

   logic feedback;

   assign feedback = ^(state & TAPS);
   assign at_seed  = (state == SEED);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state <= SEED;
      end else if (step) begin
         state <= {state[W-2:0], feedback};
      end
   end

endmodule

// File: rtl/pairhist_match.sv
module pairhist_match
   import pairhist_pkg::*;
#(
   parameter int unsigned WAYS  = 16,
   parameter int unsigned TAG_W = 21
) (
   input  logic [WAYS-1:0]                  valid,
   input  logic [WAYS-1:0][TAG_W-1:0]       in_tags,
   input  logic [WAYS-1:0][TAG_W-1:0]       out_tags,
   input  logic                             demand,
   input  logic                             miss,
   input  logic [TAG_W-1:0]                 req_tag,
   input  logic [TAG_W-1:0]                 vic_tag,
   output logic [WAYS-1:0][PH_CODE_W-1:0]   codes,
   output logic [WAYS-1:0]                  hits
);

   generate
      for (genvar w = 0; w < WAYS; w++) begin : g_way
         logic ins_hit;
         logic out_hit;
         logic vic_hit;

         assign ins_hit = valid[w] && demand && (in_tags[w] == req_tag);
         assign out_hit = valid[w] && demand && (out_tags[w] == req_tag);
         assign vic_hit = valid[w] && miss && (in_tags[w] == vic_tag);

         assign codes[w] = ins_hit ? PH_CODE_W'(EV_INSERT_WON) :
                           out_hit ? PH_CODE_W'(EV_VICTIM_WON) :
                           vic_hit ? PH_CODE_W'(EV_NEITHER)    :
                                     PH_CODE_W'(EV_NONE);
         assign hits[w]  = ins_hit | out_hit | vic_hit;
      end
   endgenerate

endmodule

// File: rtl/pairhist_lru.sv
module pairhist_lru #(
   parameter int unsigned WAYS  = 16,
   parameter int unsigned AGE_W = $clog2(WAYS),
   parameter int unsigned WAY_W = $clog2(WAYS)
) (
   input  logic [WAYS-1:0]             valid_left,
   input  logic [WAYS-1:0][AGE_W-1:0]  ages,
   output logic                        free_any,
   output logic [WAY_W-1:0]            tgt_way,
   output logic [WAYS-1:0][AGE_W-1:0]  ages_next
);

   localparam logic [AGE_W-1:0] AGE_MAX = AGE_W'(WAYS - 1);

   logic [WAY_W-1:0] free_way;
   logic [WAY_W-1:0] old_way;
   logic [AGE_W-1:0] tgt_age;

   always_comb begin
      free_any = 1'b0;
      free_way = '0;
      for (int w = WAYS - 1; w >= 0; w--) begin
         if (!valid_left[w]) begin
            free_any = 1'b1;
            free_way = WAY_W'(w);
         end
      end
   end

   always_comb begin
      old_way = '0;
      for (int w = 0; w < WAYS; w++) begin
         if (ages[w] == AGE_MAX) begin
            old_way = WAY_W'(w);
         end
      end
   end

   assign tgt_way = free_any ? free_way : old_way;
   assign tgt_age = ages[tgt_way];

   always_comb begin
      for (int w = 0; w < WAYS; w++) begin
         if (WAY_W'(w) == tgt_way) begin
            ages_next[w] = '0;
         end else if (ages[w] < tgt_age) begin
            ages_next[w] = ages[w] + AGE_W'(1);
         end else begin
            ages_next[w] = ages[w];
         end
      end
   end

endmodule

// File: rtl/pairhist_evq.sv
module pairhist_evq
   import pairhist_pkg::*;
#(
   parameter int unsigned WAYS  = 16,
   parameter int unsigned SIG_W = 10,
   parameter int unsigned WAY_W = $clog2(WAYS)
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            load,
   input  logic [WAYS-1:0]                 load_vec,
   input  logic [WAYS-1:0][PH_CODE_W-1:0]  load_codes,
   input  logic [WAYS-1:0][SIG_W-1:0]      load_sigs,
   input  logic [WAYS-1:0]                 load_pf,
   output logic [WAYS-1:0]                 pend,
   output logic                            busy,
   output logic [PH_CODE_W-1:0]            evt_code,
   output logic [SIG_W-1:0]                evt_sig,
   output logic                            evt_pf
);

   logic [WAYS-1:0][PH_CODE_W-1:0] code_q;
   logic [WAYS-1:0][SIG_W-1:0]     sig_q;
   logic [WAYS-1:0]                pf_q;
   logic [WAYS-1:0]                first_oh;
   logic [WAY_W-1:0]               first_idx;

   assign busy     = |pend;
   assign first_oh = pend & (~pend + WAYS'(1));

   always_comb begin
      first_idx = '0;
      for (int w = 0; w < WAYS; w++) begin
         if (first_oh[w]) begin
            first_idx = WAY_W'(w);
         end
      end
   end

   assign evt_code = code_q[first_idx];
   assign evt_sig  = sig_q[first_idx];
   assign evt_pf   = pf_q[first_idx];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend <= '0;
      end else if (load) begin
         pend <= load_vec;
      end else begin
         pend <= pend & ~first_oh;
      end
   end

   always_ff @(posedge clk) begin
      if (load) begin
         code_q <= load_codes;
         sig_q  <= load_sigs;
         pf_q   <= load_pf;
      end
   end

endmodule

// File: rtl/pairhist_tracker.sv
module pairhist_tracker
   import pairhist_pkg::*;
#(
   parameter int unsigned  WAYS      = 16,
   parameter int unsigned  SETS      = 8,
   parameter int unsigned  TAG_W     = 21,
   parameter int unsigned  SIG_W     = 10,
   parameter int unsigned  CORE_W    = 2,
   parameter int unsigned  LFSR_W    = 9,
   parameter logic [LFSR_W-1:0] LFSR_TAPS = 9'h110,
   parameter logic [LFSR_W-1:0] LFSR_SEED = 9'h001,
   localparam int unsigned SET_W     = $clog2(SETS),
   localparam int unsigned WAY_W     = $clog2(WAYS),
   localparam int unsigned AGE_W     = $clog2(WAYS),
   localparam int unsigned ADDR_W    = TAG_W + SET_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acc_valid,
   output logic              acc_ready,
   input  logic              acc_demand,
   input  logic              acc_miss,
   input  logic [ADDR_W-1:0] acc_addr,
   input  logic [TAG_W-1:0]  acc_victim_tag,
   input  logic [SIG_W-1:0]  acc_pc_sig,
   input  logic [CORE_W-1:0] acc_core,
   output logic              evt_valid,
   output logic [1:0]        evt_code,
   output logic [SIG_W-1:0]  evt_sig,
   output logic              evt_pf
);

   generate
      if (WAYS < 2 || (1 << WAY_W) != WAYS) begin : g_bad_ways
         $error("pairhist_tracker: WAYS must be a power of two >= 2");
      end
      if (SETS < 2 || (1 << SET_W) != SETS) begin : g_bad_sets
         $error("pairhist_tracker: SETS must be a power of two >= 2");
      end
      if (CORE_W > SIG_W) begin : g_bad_core
         $error("pairhist_tracker: core number wider than signature");
      end
   endgenerate

   // record storage
   logic [SETS-1:0][WAYS-1:0]             valid_q;
   logic [SETS-1:0][WAYS-1:0][AGE_W-1:0]  age_q;
   logic [SETS-1:0][WAYS-1:0][TAG_W-1:0]  in_tag_q;
   logic [SETS-1:0][WAYS-1:0][TAG_W-1:0]  out_tag_q;
   logic [SETS-1:0][WAYS-1:0][SIG_W-1:0]  sig_q;
   logic [SETS-1:0][WAYS-1:0]             pf_q;

   logic                            fire;
   logic [SET_W-1:0]                set_idx;
   logic [TAG_W-1:0]                req_tag;
   logic [WAYS-1:0][PH_CODE_W-1:0]  match_codes;
   logic [WAYS-1:0]                 match_hits;
   logic [WAYS-1:0]                 valid_left;
   logic                            free_any;
   logic [WAY_W-1:0]                tgt_way;
   logic [WAYS-1:0][AGE_W-1:0]      ages_next;
   logic [LFSR_W-1:0]               lfsr_state;
   logic                            lfsr_at_seed;
   logic                            full_miss;
   logic                            record;
   logic [SIG_W-1:0]                new_sig;
   logic [WAYS-1:0]                 pend_w;
   logic                            evq_busy;
   logic [PH_CODE_W-1:0]            evq_code;

   assign acc_ready = ~evq_busy;
   assign fire      = acc_valid & acc_ready;
   assign set_idx   = acc_addr[TAG_W +: SET_W];
   assign req_tag   = acc_addr[TAG_W-1:0];
   assign new_sig   = acc_demand ? acc_pc_sig : SIG_W'(acc_core);

   pairhist_match #(
      .WAYS  (WAYS),
      .TAG_W (TAG_W)
   ) i_match (
      .valid    (valid_q[set_idx]),
      .in_tags  (in_tag_q[set_idx]),
      .out_tags (out_tag_q[set_idx]),
      .demand   (acc_demand),
      .miss     (acc_miss),
      .req_tag  (req_tag),
      .vic_tag  (acc_victim_tag),
      .codes    (match_codes),
      .hits     (match_hits)
   );

   assign valid_left = valid_q[set_idx] & ~match_hits;

   pairhist_lru #(
      .WAYS  (WAYS),
      .AGE_W (AGE_W),
      .WAY_W (WAY_W)
   ) i_lru (
      .valid_left (valid_left),
      .ages       (age_q[set_idx]),
      .free_any   (free_any),
      .tgt_way    (tgt_way),
      .ages_next  (ages_next)
   );

   assign full_miss = fire & acc_miss & ~free_any;
   assign record    = fire & acc_miss & (free_any | lfsr_at_seed);

   pairhist_lfsr #(
      .W    (LFSR_W),
      .TAPS (LFSR_TAPS),
      .SEED (LFSR_SEED)
   ) i_lfsr (
      .clk     (clk),
      .rst_n   (rst_n),
      .step    (full_miss),
      .state   (lfsr_state),
      .at_seed (lfsr_at_seed)
   );

   pairhist_evq #(
      .WAYS  (WAYS),
      .SIG_W (SIG_W),
      .WAY_W (WAY_W)
   ) i_evq (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (fire),
      .load_vec   (match_hits),
      .load_codes (match_codes),
      .load_sigs  (sig_q[set_idx]),
      .load_pf    (pf_q[set_idx]),
      .pend       (pend_w),
      .busy       (evq_busy),
      .evt_code   (evq_code),
      .evt_sig    (evt_sig),
      .evt_pf     (evt_pf)
   );

   assign evt_valid = evq_busy;
   assign evt_code  = evq_code;

   // valid bits and replacement ages
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_q <= '0;
         for (int s = 0; s < SETS; s++) begin
            for (int w = 0; w < WAYS; w++) begin
               age_q[s][w] <= AGE_W'(w);
            end
         end
      end else if (fire) begin
         if (record) begin
            valid_q[set_idx]          <= valid_left;
            valid_q[set_idx][tgt_way] <= 1'b1;
            age_q[set_idx]            <= ages_next;
         end else begin
            valid_q[set_idx] <= valid_left;
         end
      end
   end

   // pair payload
   always_ff @(posedge clk) begin
      if (record) begin
         in_tag_q[set_idx][tgt_way]  <= req_tag;
         out_tag_q[set_idx][tgt_way] <= acc_victim_tag;
         sig_q[set_idx][tgt_way]     <= new_sig;
         pf_q[set_idx][tgt_way]      <= ~acc_demand;
      end
   end

endmodule

// File: rtl/pairhist_checker.sv
module pairhist_checker #(
   parameter int unsigned WAYS   = 16,
   parameter int unsigned SETS   = 8,
   parameter int unsigned AGE_W  = 4,
   parameter int unsigned LFSR_W = 9
) (
   input logic                             clk,
   input logic                             rst_n,
   input logic                             acc_fire,
   input logic                             acc_demand,
   input logic                             acc_miss,
   input logic                             evt_valid,
   input logic [1:0]                       evt_code,
   input logic [WAYS-1:0]                  pend,
   input logic [SETS-1:0][WAYS-1:0]        valid_all,
   input logic [SETS-1:0][WAYS-1:0][AGE_W-1:0] ages,
   input logic [LFSR_W-1:0]                lfsr
);

   logic [SETS-1:0][WAYS-1:0] is_oldest;

   always_comb begin
      for (int s = 0; s < SETS; s++) begin
         for (int w = 0; w < WAYS; w++) begin
            is_oldest[s][w] = (ages[s][w] == AGE_W'(WAYS - 1));
         end
      end
   end

   generate
      for (genvar s = 0; s < SETS; s++) begin : g_set
         assert_single_oldest_R10: assert property (@(posedge clk) disable iff (!rst_n)
            $countones(is_oldest[s]) == 1);
      end
   endgenerate

   assert_event_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
      evt_valid |-> evt_code != 2'd0);

   assert_drain_one_per_cycle_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (pend != '0 && !acc_fire) |=> $countones(pend) == $countones($past(pend)) - 1);

   assert_event_after_accept_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(evt_valid) |-> $past(acc_fire));

   assert_prefetch_hit_silent_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_fire && !acc_demand && !acc_miss) |=> !evt_valid);

   assert_record_needs_miss_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ($countones(valid_all) > $countones($past(valid_all))) |-> $past(acc_fire && acc_miss));

   assert_lfsr_alive_R9: assert property (@(posedge clk) disable iff (!rst_n)
      lfsr != '0);

endmodule

bind pairhist_tracker pairhist_checker #(
   .WAYS   (WAYS),
   .SETS   (SETS),
   .AGE_W  (AGE_W),
   .LFSR_W (LFSR_W)
) i_pairhist_checker (
   .clk        (clk),
   .rst_n      (rst_n),
   .acc_fire   (fire),
   .acc_demand (acc_demand),
   .acc_miss   (acc_miss),
   .evt_valid  (evt_valid),
   .evt_code   (evt_code),
   .pend       (pend_w),
   .valid_all  (valid_q),
   .ages       (age_q),
   .lfsr       (lfsr_state)
);

// File: tb/test_pairhist_tracker.sv
module test_pairhist_tracker;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        acc_valid = 1'b0;
   logic        acc_ready;
   logic        acc_demand = 1'b1;
   logic        acc_miss = 1'b0;
   logic [23:0] acc_addr = '0;
   logic [20:0] acc_victim_tag = '0;
   logic [9:0]  acc_pc_sig = '0;
   logic [1:0]  acc_core = '0;
   logic        evt_valid;
   logic [1:0]  evt_code;
   logic [9:0]  evt_sig;
   logic        evt_pf;

   int checks = 0;
   int errors = 0;
   int ev_n;
   int ev_code [0:15];
   int ev_sig  [0:15];
   int ev_pf   [0:15];
   bit rdy_bad;

   always #4 clk = ~clk;

   pairhist_tracker i_pairhist_tracker (
      .clk            (clk),
      .rst_n          (rst_n),
      .acc_valid      (acc_valid),
      .acc_ready      (acc_ready),
      .acc_demand     (acc_demand),
      .acc_miss       (acc_miss),
      .acc_addr       (acc_addr),
      .acc_victim_tag (acc_victim_tag),
      .acc_pc_sig     (acc_pc_sig),
      .acc_core       (acc_core),
      .evt_valid      (evt_valid),
      .evt_code       (evt_code),
      .evt_sig        (evt_sig),
      .evt_pf         (evt_pf)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic access(input bit dem, input bit miss, input int set, input int tag,
                         input int vic, input int sig, input int core);
      @(negedge clk);
      while (!acc_ready) @(negedge clk);
      acc_valid      = 1'b1;
      acc_demand     = dem;
      acc_miss       = miss;
      acc_addr       = {set[2:0], tag[20:0]};
      acc_victim_tag = vic[20:0];
      acc_pc_sig     = sig[9:0];
      acc_core       = core[1:0];
      @(posedge clk);
      @(negedge clk);
      acc_valid = 1'b0;
      ev_n = 0;
      rdy_bad = 1'b0;
      while (evt_valid) begin
         if (acc_ready) rdy_bad = 1'b1;
         if (ev_n < 16) begin
            ev_code[ev_n] = int'(evt_code);
            ev_sig[ev_n]  = int'(evt_sig);
            ev_pf[ev_n]   = int'(evt_pf);
         end
         ev_n++;
         @(negedge clk);
      end
   endtask

   task automatic expect_none(input string req);
      chk({req, " event count"}, ev_n, 0);
   endtask

   task automatic expect_one(input string req, input int code, input int sig, input int pf);
      chk({req, " event count"}, ev_n, 1);
      if (ev_n >= 1) begin
         chk({req, " code"}, ev_code[0], code);
         chk({req, " sig"}, ev_sig[0], sig);
         chk({req, " pf"}, ev_pf[0], pf);
      end
   endtask

   task automatic t_reset;
      @(negedge clk);
      chk("R1 evt_valid after reset", int'(evt_valid), 0);
      chk("R1 acc_ready after reset", int'(acc_ready), 1);
   endtask

   task automatic t_insert_won;
      access(1, 1, 1, 'h0000A1, 'h0000B1, 'h155, 0);
      expect_none("R8 record into free way");
      access(1, 0, 1, 'h0000A1, 0, 0, 0);
      expect_one("R2 insert tag touched", 1, 'h155, 0);
      access(1, 0, 1, 'h0000A1, 0, 0, 0);
      expect_none("R2 retired record");
   endtask

   task automatic t_victim_won;
      access(1, 1, 2, 'h0000A2, 'h0000B2, 'h2AA, 0);
      access(1, 0, 2, 'h0000B2, 0, 0, 0);
      expect_one("R3 evict tag touched", 2, 'h2AA, 0);
      access(1, 0, 2, 'h0000A2, 0, 0, 0);
      expect_none("R3 retired record");
   endtask

   task automatic t_neither;
      access(1, 1, 3, 'h0000C3, 'h0000D3, 'h0F0, 0);
      access(0, 1, 3, 'h0000E3, 'h0000C3, 0, 1);
      expect_one("R4 victim candidate hits insert tag", 3, 'h0F0, 0);
      access(0, 1, 3, 'h0000F3, 'h0000C3, 0, 1);
      expect_none("R4 retired record");
   endtask

   task automatic t_prefetch;
      access(0, 1, 4, 'h0000A4, 'h0000B4, 'h3FF, 2);
      access(0, 0, 4, 'h0000A4, 0, 0, 2);
      expect_none("R5 prefetch on insert tag");
      access(0, 0, 4, 'h0000B4, 0, 0, 2);
      expect_none("R5 prefetch on evict tag");
      access(1, 0, 4, 'h0000A4, 0, 0, 0);
      expect_one("R5 prefetch record sig=core pf=1", 1, 2, 1);
   endtask

   task automatic t_multi;
      access(1, 1, 5, 'h0000A5, 'h0000F5, 'h011, 0);
      access(1, 1, 5, 'h0000B5, 'h0000F5, 'h022, 0);
      access(1, 1, 5, 'h0000C5, 'h0000F5, 'h033, 0);
      access(1, 0, 5, 'h0000F5, 0, 0, 0);
      chk("R6 multi-match event count", ev_n, 3);
      if (ev_n == 3) begin
         chk("R6 first event sig", ev_sig[0], 'h011);
         chk("R6 second event sig", ev_sig[1], 'h022);
         chk("R6 third event sig", ev_sig[2], 'h033);
         chk("R6 codes", ev_code[0] + ev_code[1] + ev_code[2], 6);
      end
      chk("R6 ready low while pending", int'(rdy_bad), 0);
   endtask

   task automatic t_priority;
      access(1, 1, 6, 'h0000A6, 'h0000A6, 'h061, 0);
      access(1, 0, 6, 'h0000A6, 0, 0, 0);
      expect_one("R7 insert beats evict", 1, 'h061, 0);
      access(1, 1, 6, 'h0000B6, 'h0000C6, 'h062, 0);
      access(1, 1, 6, 'h0000C6, 'h0000B6, 'h063, 0);
      expect_one("R7 evict beats victim candidate", 2, 'h062, 0);
      access(1, 0, 6, 'h0000B6, 0, 0, 0);
      expect_one("R8 miss that retired also recorded", 2, 'h063, 0);
   endtask

   task automatic t_sets;
      access(1, 1, 7, 'h0000A7, 'h0000B7, 'h077, 0);
      access(1, 0, 5, 'h0000A7, 0, 0, 0);
      expect_none("R8 other set does not match");
      access(1, 0, 7, 'h0000A7, 0, 0, 0);
      expect_one("R8 own set matches", 1, 'h077, 0);
   endtask

   task automatic t_full;
      int total;
      for (int k = 0; k < 16; k++) begin
         access(1, 1, 0, 'h100000 + k, 'h0A0000 + k, k, 0);
      end
      total = 0;
      for (int k = 0; k < 512; k++) begin
         access(1, 1, 0, 'h180000 + k, 'h0B0000 + k, 'h200 + (k % 256), 0);
         total += ev_n;
      end
      chk("R9 full-set misses raise no events", total, 0);
      access(1, 0, 0, 'h100000, 0, 0, 0);
      expect_none("R10 oldest record overwritten");
      access(1, 0, 0, 'h100001, 0, 0, 0);
      expect_none("R10 second oldest overwritten at LFSR return");
      access(1, 0, 0, 'h180001, 0, 0, 0);
      expect_none("R9 second full-set miss not recorded");
      access(1, 0, 0, 'h180000, 0, 0, 0);
      expect_one("R9 first full-set miss recorded", 1, 'h200, 0);
      access(1, 0, 0, 'h180000 + 511, 0, 0, 0);
      expect_one("R9 miss 511 after first recorded", 1, 'h200 + 255, 0);
      access(1, 0, 0, 'h100002, 0, 0, 0);
      expect_one("R10 younger record kept", 1, 2, 0);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_insert_won();
      t_victim_won();
      t_neither();
      t_prefetch();
      t_multi();
      t_priority();
      t_sets();
      t_full();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule